// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block caches virtual-to-physical page translations for a processor core. It holds 64 slots. Any slot can hold any page, and every slot is compared against the incoming address in the same cycle. Each slot is tagged with a 20-bit virtual page number and a 6-bit address-space identifier. Because of that tag, translations that belong to different processes can live side by side, and a context switch needs no flush. A lookup supplies a 32-bit virtual address (20-bit page number above a 12-bit page offset), the current address-space identifier, a read/write flag and a user-mode flag. One clock later the block returns the physical address together with a hit flag, a miss flag, a modification-fault flag, an address-error flag and an uncached flag.

The three top address bits pick a region:
- 0xx: user region, translated through the buffer.
- 100: kernel region mapped straight onto physical memory, cached.
- 101: kernel region mapped straight onto physical memory, uncached.
- 11x: kernel region, translated through the buffer.

The buffer never walks page tables. A miss is reported to software, which refills a chosen slot through a write port addressed by slot number. Software can also drop one slot or drop every slot at once.

A two-state response machine (`RSP_IDLE`, `RSP_SHOW`) marks when a registered result is on the outputs. The transition `GO_SHOW` is taken on any edge with `lk_valid` high. `GO_IDLE` is taken on any edge with `lk_valid` low. `STAY_SHOW` is the case of back-to-back lookups.

Top module: `asid_tlb`

## Requirements
- R1: `res_valid` is high in exactly the cycle after each cycle where `lk_valid` was high, and low otherwise. All result flags are low whenever `res_valid` is low.
- R2: In a translated region (top bits 0xx or 11x), a lookup hits when some valid slot holds both the address's page number (`lk_vaddr[31:12]`) and `lk_asid`. The result then has `res_hit`=1 and `res_paddr`={slot page frame, `lk_vaddr[11:0]`}, and `res_uncached` equals the slot's no-cache bit.
- R3: A translated lookup with no valid slot matching both page number and identifier gives `res_miss`=1, `res_hit`=0 and `res_paddr`=0. A slot whose page number matches but whose identifier differs does not hit.
- R4: With `lk_user`=0 and top bits 100 or 101, the buffer is bypassed. `res_paddr` is the virtual address with its top three bits cleared, `res_hit`=`res_miss`=0, and `res_uncached` is 1 only for 101.
- R5: With `lk_user`=1 and `lk_vaddr[31]`=1, the result is `res_addr_err`=1 with hit, miss and fault all 0, `res_paddr`=0, and no slot's referenced state changes.
- R6: A write lookup (`lk_write`=1) that hits a slot whose write-enable bit is clear gives `res_mod_fault`=1 alongside `res_hit`=1. A read to that slot, or a write to a slot with the bit set, gives `res_mod_fault`=0.
- R7: On a hit, `res_ref_prev` shows the slot's referenced bit as it stood before the lookup, and the hit sets that bit. A refill clears it. `res_ref_prev` is 0 whenever there is no hit.
- R8: A cycle with `wr_en`=1 replaces the whole slot at `wr_index`; lookups from the next cycle on see the new contents.
- R9: `inv_one`=1 clears the valid bit of slot `inv_index` from the next cycle on, taking priority over a write to the same slot.
- R10: `inv_all`=1 clears the valid bit of every slot from the next cycle on, taking priority over any write or single invalidate.
- R11: When several valid slots match, the lowest-numbered one supplies the result.
- R12: After reset every slot is invalid and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Current address-space identifier |
| lk_write | input | 1 | 1 = store access, 0 = load |
| lk_user | input | 1 | 1 = user mode |
| res_valid | output | 1 | Result present (one cycle after request) |
| res_paddr | output | 32 | Physical address |
| res_hit | output | 1 | Matching slot found |
| res_miss | output | 1 | Translated access with no matching slot |
| res_addr_err | output | 1 | User access to a kernel region |
| res_mod_fault | output | 1 | Store to a slot without write permission |
| res_uncached | output | 1 | Access must bypass the data cache |
| res_ref_prev | output | 1 | Referenced bit of the hit slot before this lookup |
| wr_en | input | 1 | Refill a slot |
| wr_index | input | 6 | Slot to refill |
| wr_vpn | input | 20 | Virtual page number for the slot |
| wr_asid | input | 6 | Address-space identifier for the slot |
| wr_ppn | input | 20 | Physical page frame for the slot |
| wr_dirty | input | 1 | Write-enable (dirty) bit for the slot |
| wr_nocache | input | 1 | Slot maps uncached memory |
| wr_valid | input | 1 | Valid bit for the slot |
| inv_one | input | 1 | Invalidate one slot |
| inv_index | input | 6 | Slot to invalidate |
| inv_all | input | 1 | Invalidate every slot |

## Verification
The assertions watch several things on every cycle:
- The one-cycle response timing.
- That hit, miss and address error never appear together.
- That a modification fault never appears without a hit.
- That user accesses to kernel space always raise an address error.
- That bypass addresses have their top bits cleared.
- That either invalidate really clears the valid state.

Only the bench scenarios can show the rest: the right frame coming back for a given page and identifier, lowest-slot priority among duplicates, the referenced bit being set by a hit and cleared by a refill, and identifier isolation. All of these depend on stored contents that a single-cycle property cannot see.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        RG_USER,
        RG_KPHYS_C,
        RG_KPHYS_U,
        RG_KVIRT
    } region_e;

    typedef enum logic {
        RSP_IDLE,
        RSP_SHOW
    } rsp_state_e;
endpackage

// File: rtl/tlb_region_decode.sv
module tlb_region_decode
    import tlb_pkg::*;
(
    input  logic [2:0] top_bits,
    input  logic       user_mode,
    output region_e    region,
    output logic       translate,
    output logic       addr_err
);
    always_comb begin
        unique casez (top_bits)
            3'b0??:  region = RG_USER;
            3'b100:  region = RG_KPHYS_C;
            3'b101:  region = RG_KPHYS_U;
            default: region = RG_KVIRT;
        endcase
        addr_err  = user_mode && (region != RG_USER);
        translate = !addr_err && (region == RG_USER || region == RG_KVIRT);
    end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ASID_W  = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [$clog2(ENTRIES)-1:0]       wr_index,
    input  logic [VPN_W-1:0]                 wr_vpn,
    input  logic [ASID_W-1:0]                wr_asid,
    input  logic [PPN_W-1:0]                 wr_ppn,
    input  logic                             wr_dirty,
    input  logic                             wr_nocache,
    input  logic                             wr_valid,
    input  logic                             inv_one,
    input  logic [$clog2(ENTRIES)-1:0]       inv_index,
    input  logic                             inv_all,
    input  logic                             ref_set,
    input  logic [$clog2(ENTRIES)-1:0]       ref_index,
    output logic [ENTRIES-1:0]               valid_o,
    output logic [ENTRIES-1:0][VPN_W-1:0]    vpn_o,
    output logic [ENTRIES-1:0][ASID_W-1:0]   asid_o,
    output logic [ENTRIES-1:0][PPN_W-1:0]    ppn_o,
    output logic [ENTRIES-1:0]               dirty_o,
    output logic [ENTRIES-1:0]               nocache_o,
    output logic [ENTRIES-1:0]               ref_o
);
    logic [ENTRIES-1:0]             valid_q, dirty_q, nocache_q, ref_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;

    // Later statements win: refill over reference update, invalidates over refill.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= '0;
            dirty_q   <= '0;
            nocache_q <= '0;
            ref_q     <= '0;
            vpn_q     <= '0;
            asid_q    <= '0;
            ppn_q     <= '0;
        end else begin
            if (ref_set)
                ref_q[ref_index] <= 1'b1;
            if (wr_en) begin
                vpn_q[wr_index]     <= wr_vpn;
                asid_q[wr_index]    <= wr_asid;
                ppn_q[wr_index]     <= wr_ppn;
                dirty_q[wr_index]   <= wr_dirty;
                nocache_q[wr_index] <= wr_nocache;
                valid_q[wr_index]   <= wr_valid;
                ref_q[wr_index]     <= 1'b0;
            end
            if (inv_one)
                valid_q[inv_index] <= 1'b0;
            if (inv_all)
                valid_q <= '0;
        end
    end

    assign valid_o   = valid_q;
    assign vpn_o     = vpn_q;
    assign asid_o    = asid_q;
    assign ppn_o     = ppn_q;
    assign dirty_o   = dirty_q;
    assign nocache_o = nocache_q;
    assign ref_o     = ref_q;

    // R10
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_q == '0));

    // R9
    drop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_one |=> !valid_q[$past(inv_index)]);
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 6
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid,
    input  logic [VPN_W-1:0]               look_vpn,
    input  logic [ASID_W-1:0]              look_asid,
    output logic                           hit,
    output logic [$clog2(ENTRIES)-1:0]     hit_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid[g] && (vpn[g] == look_vpn) && (asid[g] == look_asid);
    end

    // Scan downward so the lowest matching slot is the last one assigned.
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i])
                hit_idx = IDX_W'(i);
        end
        hit = |match_vec;
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 32,
    parameter int PAGE_W  = 12,
    parameter int PPN_W   = 20,
    parameter int ASID_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic [VA_W-1:0]            lk_vaddr,
    input  logic [ASID_W-1:0]          lk_asid,
    input  logic                       lk_write,
    input  logic                       lk_user,
    output logic                       res_valid,
    output logic [PPN_W+PAGE_W-1:0]    res_paddr,
    output logic                       res_hit,
    output logic                       res_miss,
    output logic                       res_addr_err,
    output logic                       res_mod_fault,
    output logic                       res_uncached,
    output logic                       res_ref_prev,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_index,
    input  logic [VA_W-PAGE_W-1:0]     wr_vpn,
    input  logic [ASID_W-1:0]          wr_asid,
    input  logic [PPN_W-1:0]           wr_ppn,
    input  logic                       wr_dirty,
    input  logic                       wr_nocache,
    input  logic                       wr_valid,
    input  logic                       inv_one,
    input  logic [$clog2(ENTRIES)-1:0] inv_index,
    input  logic                       inv_all
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PA_W  = PPN_W + PAGE_W;

    logic [ENTRIES-1:0]             e_valid, e_dirty, e_nocache, e_ref;
    logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
    logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
    logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;

    region_e    region;
    logic       translate, addr_err_now;
    logic       cam_hit;
    logic [IDX_W-1:0] cam_idx;
    logic       hit_now, ref_set;
    rsp_state_e state_q, state_d;

    tlb_region_decode u_region (
        .top_bits  (lk_vaddr[VA_W-1 -: 3]),
        .user_mode (lk_user),
        .region    (region),
        .translate (translate),
        .addr_err  (addr_err_now)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
        .valid     (e_valid),
        .vpn       (e_vpn),
        .asid      (e_asid),
        .look_vpn  (lk_vaddr[VA_W-1:PAGE_W]),
        .look_asid (lk_asid),
        .hit       (cam_hit),
        .hit_idx   (cam_idx)
    );

    assign hit_now = translate && cam_hit;
    assign ref_set = lk_valid && hit_now;

    tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_index   (wr_index),
        .wr_vpn     (wr_vpn),
        .wr_asid    (wr_asid),
        .wr_ppn     (wr_ppn),
        .wr_dirty   (wr_dirty),
        .wr_nocache (wr_nocache),
        .wr_valid   (wr_valid),
        .inv_one    (inv_one),
        .inv_index  (inv_index),
        .inv_all    (inv_all),
        .ref_set    (ref_set),
        .ref_index  (cam_idx),
        .valid_o    (e_valid),
        .vpn_o      (e_vpn),
        .asid_o     (e_asid),
        .ppn_o      (e_ppn),
        .dirty_o    (e_dirty),
        .nocache_o  (e_nocache),
        .ref_o      (e_ref)
    );

    // Response machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: state_d = lk_valid ? RSP_SHOW : RSP_IDLE;
            RSP_SHOW: state_d = lk_valid ? RSP_SHOW : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    assign res_valid = (state_q == RSP_SHOW);

    // Response machine: registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_paddr     <= '0;
            res_hit       <= 1'b0;
            res_miss      <= 1'b0;
            res_addr_err  <= 1'b0;
            res_mod_fault <= 1'b0;
            res_uncached  <= 1'b0;
            res_ref_prev  <= 1'b0;
        end else begin
            res_paddr     <= '0;
            res_hit       <= 1'b0;
            res_miss      <= 1'b0;
            res_addr_err  <= 1'b0;
            res_mod_fault <= 1'b0;
            res_uncached  <= 1'b0;
            res_ref_prev  <= 1'b0;
            if (lk_valid) begin
                if (addr_err_now) begin
                    res_addr_err <= 1'b1;
                end else if (!translate) begin
                    res_paddr    <= PA_W'(lk_vaddr[VA_W-4:0]);
                    res_uncached <= (region == RG_KPHYS_U);
                end else if (cam_hit) begin
                    res_hit       <= 1'b1;
                    res_paddr     <= {e_ppn[cam_idx], lk_vaddr[PAGE_W-1:0]};
                    res_uncached  <= e_nocache[cam_idx];
                    res_mod_fault <= lk_write && !e_dirty[cam_idx];
                    res_ref_prev  <= e_ref[cam_idx];
                end else begin
                    res_miss <= 1'b1;
                end
            end
        end
    end

    // R1
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R1
    resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(res_valid || res_hit || res_miss || res_addr_err));

    // R3
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0({res_hit, res_miss, res_addr_err}));

    // R5
    user_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_user && lk_vaddr[VA_W-1]) |=> (res_addr_err && !res_hit && !res_miss));

    // R6
    mod_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_mod_fault |-> res_hit);

    // R4
    bypass_paddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_user && lk_vaddr[VA_W-1 -: 2] == 2'b10)
        |=> (res_paddr[PA_W-1 -: 3] == 3'b000 && !res_hit && !res_miss));
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        res_valid, res_hit, res_miss, res_addr_err, res_mod_fault, res_uncached, res_ref_prev;
    logic [31:0] res_paddr;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_index = '0;
    logic [19:0] wr_vpn = '0;
    logic [5:0]  wr_asid = '0;
    logic [19:0] wr_ppn = '0;
    logic        wr_dirty = 1'b0, wr_nocache = 1'b0, wr_valid = 1'b0;
    logic        inv_one = 1'b0;
    logic [5:0]  inv_index = '0;
    logic        inv_all = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Bench-side model of slot contents
    logic        m_valid [N];
    logic [19:0] m_vpn   [N];
    logic [5:0]  m_asid  [N];
    logic [19:0] m_ppn   [N];
    logic        m_dirty [N];
    logic        m_nc    [N];
    logic        m_ref   [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    asid_tlb u_asid_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_write(lk_write), .lk_user(lk_user),
        .res_valid(res_valid), .res_paddr(res_paddr), .res_hit(res_hit),
        .res_miss(res_miss), .res_addr_err(res_addr_err), .res_mod_fault(res_mod_fault),
        .res_uncached(res_uncached), .res_ref_prev(res_ref_prev),
        .wr_en(wr_en), .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_ppn(wr_ppn), .wr_dirty(wr_dirty), .wr_nocache(wr_nocache), .wr_valid(wr_valid),
        .inv_one(inv_one), .inv_index(inv_index), .inv_all(inv_all)
    );

    function automatic logic [38:0] pack_actual();
        return {res_valid, res_hit, res_miss, res_addr_err, res_mod_fault,
                res_uncached, res_ref_prev, res_paddr};
    endfunction

    task automatic check(input string req, input logic [38:0] act, input logic [38:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result from the requirements; idx returns the hit slot or -1
    function automatic logic [38:0] expect_of(input logic [31:0] va, input logic [5:0] asid,
                                              input logic wr, input logic user, output int idx);
        logic [2:0] top;
        top = va[31:29];
        idx = -1;
        if (user && top[2])
            return {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0};   // R5
        if (top[2:1] == 2'b10)
            return {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, top[0], 1'b0, {3'b000, va[28:0]}}; // R4
        for (int i = 0; i < N; i++) begin
            if (idx < 0 && m_valid[i] && m_vpn[i] == va[31:12] && m_asid[i] == asid)
                idx = i;   // R11 lowest slot
        end
        if (idx < 0)
            return {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0};   // R3
        return {1'b1, 1'b1, 1'b0, 1'b0, wr && !m_dirty[idx], m_nc[idx], m_ref[idx],
                {m_ppn[idx], va[11:0]}};                                 // R2 R6 R7
    endfunction

    task automatic do_write(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                            input logic [19:0] ppn, input logic dirty, input logic nc,
                            input logic valid);
        @(negedge clk);
        wr_en = 1'b1; wr_index = 6'(idx); wr_vpn = vpn; wr_asid = asid;
        wr_ppn = ppn; wr_dirty = dirty; wr_nocache = nc; wr_valid = valid;
        @(negedge clk);
        wr_en = 1'b0;
        m_valid[idx] = valid; m_vpn[idx] = vpn; m_asid[idx] = asid; m_ppn[idx] = ppn;
        m_dirty[idx] = dirty; m_nc[idx] = nc; m_ref[idx] = 1'b0;
    endtask

    task automatic do_inv_one(input int idx);
        @(negedge clk);
        inv_one = 1'b1; inv_index = 6'(idx);
        @(negedge clk);
        inv_one = 1'b0;
        m_valid[idx] = 1'b0;
    endtask

    task automatic do_inv_all();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    endtask

    task automatic do_lookup(input string req, input logic [31:0] va, input logic [5:0] asid,
                             input logic wr, input logic user);
        logic [38:0] exp;
        int idx;
        @(negedge clk);
        exp = expect_of(va, asid, wr, user, idx);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_write = wr; lk_user = user;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, pack_actual(), exp);
        if (idx >= 0) m_ref[idx] = 1'b1;
        @(negedge clk);
        check("R1 idle after result", pack_actual(), 39'h0);
    endtask

    initial begin
        void'($urandom(32'd777));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_vpn[i] = '0; m_asid[i] = '0; m_ppn[i] = '0;
            m_dirty[i] = 1'b0; m_nc[i] = 1'b0; m_ref[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R12 reset outputs", pack_actual(), 39'h0);
        rst_n = 1'b1;

        // R12: empty after reset
        do_lookup("R12 empty miss", 32'h0001_2345, 6'd3, 1'b0, 1'b1);

        // R2 R8 R7: refill then hit twice
        do_write(5, 20'h00012, 6'd3, 20'hABCDE, 1'b1, 1'b0, 1'b1);
        do_lookup("R2 R8 first hit ref clear", 32'h0001_2345, 6'd3, 1'b0, 1'b1);
        do_lookup("R7 second hit ref set", 32'h0001_2FFF, 6'd3, 1'b1, 1'b1);

        // R3: identifier isolation
        do_lookup("R3 other asid miss", 32'h0001_2345, 6'd4, 1'b0, 1'b1);

        // R4: bypass regions
        do_lookup("R4 cached bypass", 32'h8123_4567, 6'd0, 1'b0, 1'b0);
        do_lookup("R4 uncached bypass", 32'hA123_4567, 6'd0, 1'b1, 1'b0);

        // R5: user access to kernel space
        do_lookup("R5 user to kphys", 32'h8123_4567, 6'd3, 1'b0, 1'b1);
        do_write(6, 20'hC0001, 6'd1, 20'h11111, 1'b0, 1'b1, 1'b1);
        do_lookup("R5 user to kvirt", 32'hC000_1ABC, 6'd1, 1'b0, 1'b1);

        // R6 R2: kernel virtual, write-protected slot
        do_lookup("R6 read no fault ref unchanged by R5", 32'hC000_1ABC, 6'd1, 1'b0, 1'b0);
        do_lookup("R6 write fault", 32'hC000_1ABC, 6'd1, 1'b1, 1'b0);

        // R11 R9: duplicates
        do_write(20, 20'h00777, 6'd2, 20'h20000, 1'b1, 1'b0, 1'b1);
        do_write(9,  20'h00777, 6'd2, 20'h09000, 1'b1, 1'b0, 1'b1);
        do_lookup("R11 lowest slot", 32'h0077_7010, 6'd2, 1'b0, 1'b1);
        do_inv_one(9);
        do_lookup("R9 dropped slot", 32'h0077_7010, 6'd2, 1'b0, 1'b1);

        // R8 R7: refill over a referenced slot
        do_write(5, 20'h00012, 6'd3, 20'h55555, 1'b1, 1'b1, 1'b1);
        do_lookup("R8 R7 refill clears ref", 32'h0001_2001, 6'd3, 1'b0, 1'b1);

        // R10
        do_inv_all();
        do_lookup("R10 flushed", 32'h0001_2001, 6'd3, 1'b0, 1'b1);
        do_lookup("R10 flushed kvirt", 32'hC000_1ABC, 6'd1, 1'b0, 1'b0);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 99));
            if (op < 60) begin
                logic [31:0] va;
                logic [5:0]  as;
                int pick;
                pick = int'($urandom_range(0, N-1));
                as = 6'($urandom_range(0, 3));
                if ($urandom_range(0, 1) == 1) begin
                    va = {m_vpn[pick], 12'($urandom)};
                    if ($urandom_range(0, 3) != 0) as = m_asid[pick];
                end else begin
                    va = {3'($urandom), 17'($urandom_range(0, 3)), 12'($urandom)};
                end
                do_lookup("R2 random lookup", va, as, 1'($urandom), 1'($urandom));
            end else if (op < 88) begin
                do_write(int'($urandom_range(0, N-1)),
                         {3'($urandom), 17'($urandom_range(0, 3))},
                         6'($urandom_range(0, 3)), 20'($urandom),
                         1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0));
            end else if (op < 97) begin
                do_inv_one(int'($urandom_range(0, N-1)));
            end else begin
                do_inv_all();
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule